// File: doc/BRIEF.md
# UART register and interrupt front-end

This block is the software-facing side of a serial port. A processor reaches it over a simple word-addressed bus that has one select, one write strobe, a 12-bit byte address and 32-bit data, all inside a 4 KB window. The block holds the configuration words that a transmitter and receiver would use: line setup, control, integer and fractional baud divisors, the infrared low-power divisor, FIFO level select and DMA control. It also holds the interrupt mask and the raw interrupt status. The highest eight words of the window return a fixed identification byte sequence. Bit timing, DMA transfers and break handling are outside this block.

A write to the data word hands its low byte to the transmitter with a one-cycle strobe. The same write raises a sticky transmit interrupt, which stays set until software clears it. The receive path raises the receive interrupt through a one-cycle request input. Software clears status bits by writing ones to a clear word. The single interrupt line is registered, and it is high whenever any raw bit that is also enabled in the mask is set.

Top module: `uart_regfile`

## Requirements
- R1: After reset the control word reads 0x300, the FIFO level select reads 0x12 and the flag word reads 0x90. Every other register reads 0, and `irq`, `tx_valid` and `bus_rvalid` are low.
- R2: The register is chosen by address bits [11:2]. The word indices are: data 0, flags 6, low-power divisor 8, integer divisor 9, fractional divisor 10, line control 11, control 12, FIFO level 13, mask 14, raw status 15, masked status 16, clear 17, DMA control 18. A write stores the low bits of the write data. A read returns them zero-extended. The stored widths are: low-power divisor 8 bits, integer divisor 16, fractional divisor 6, line control 8, control 16, FIFO level 6, mask 11, DMA control 3.
- R3: The eight words at byte offsets 0xFE0 to 0xFFC read as 0x11, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in rising address order. Bits [31:8] of each of these words are zero.
- R4: A write to word 0 drives `tx_valid` high for exactly one cycle after the write edge, with `tx_byte` equal to write data [7:0]. The same write sets raw status bit 5, the transmit interrupt.
- R5: Raw bit 5 stays set across other accesses until a clear write that has bit 5 set.
- R6: A write to the clear word clears each raw bit that is 1 in the write data and leaves the other raw bits unchanged. If `rx_irq_set` is asserted in the same cycle, raw bit 4 ends up set.
- R7: A one-cycle pulse on `rx_irq_set` sets raw bit 4, the receive interrupt.
- R8: `irq` is high exactly when raw status AND mask is non-zero. It takes its new value at the same edge as any change to the mask or to raw status.
- R9: A read of word 15 returns raw status. A read of word 16 returns raw status AND mask.
- R10: Writes are ignored at the flag, raw, masked status and data-read positions. They are also ignored at word 1, at unmapped words and in the ID region. Reads of word 0, word 1, the clear word and unmapped words return 0. Only writes to word 0 produce `tx_valid`.
- R11: A DMA control write stores bits [2:0], including bits [1:0]. It has no other effect on the block's outputs.
- R12: A read presents its data on `bus_rdata` with `bus_rvalid` high in the cycle after the read request. A write never raises `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 12 | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| rx_irq_set | input | 1 | One-cycle receive interrupt request |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| tx_byte | output | 8 | Byte handed to the transmitter |
| tx_valid | output | 1 | One-cycle strobe for `tx_byte` |
| irq | output | 1 | Registered level interrupt |

## Verification
The bench builds the block with its default parameters: a 12-bit address, 32-bit data, an 11-bit interrupt field and the field widths listed in R2. With these values every word index and the whole ID region can be addressed. Writing all ones shows where each field truncates. The transmit and receive interrupt bits sit at the positions software expects, so mask, clear and masked read can be combined freely, including a clear write and a receive request in the same cycle.

// File: rtl/uart_regfile_pkg.sv
package uart_regfile_pkg;

  // Register selected by the current bus address
  typedef enum logic [3:0] {
    SEL_NONE, SEL_DATA, SEL_FLAGS, SEL_LPDIV, SEL_IDIV, SEL_FDIV,
    SEL_LCTL, SEL_CTRL, SEL_FLVL, SEL_MASK, SEL_RAW, SEL_MSTAT,
    SEL_CLR, SEL_DMA, SEL_ID
  } reg_sel_e;

  // Word indices (address bits [11:2])
  localparam int unsigned WIDX_DATA  = 0;
  localparam int unsigned WIDX_FLAGS = 6;
  localparam int unsigned WIDX_LPDIV = 8;
  localparam int unsigned WIDX_IDIV  = 9;
  localparam int unsigned WIDX_FDIV  = 10;
  localparam int unsigned WIDX_LCTL  = 11;
  localparam int unsigned WIDX_CTRL  = 12;
  localparam int unsigned WIDX_FLVL  = 13;
  localparam int unsigned WIDX_MASK  = 14;
  localparam int unsigned WIDX_RAW   = 15;
  localparam int unsigned WIDX_MSTAT = 16;
  localparam int unsigned WIDX_CLR   = 17;
  localparam int unsigned WIDX_DMA   = 18;

  // Interrupt bit positions in raw/mask/masked status
  localparam int unsigned TX_IRQ_BIT = 5;
  localparam int unsigned RX_IRQ_BIT = 4;

  // Identification byte for ID word n (n = 0 at the lowest ID address)
  function automatic logic [7:0] id_byte(input logic [2:0] n);
    case (n)
      3'd0:    id_byte = 8'h11;
      3'd1:    id_byte = 8'h10;
      3'd2:    id_byte = 8'h14;
      3'd3:    id_byte = 8'h00;
      3'd4:    id_byte = 8'h0D;
      3'd5:    id_byte = 8'hF0;
      3'd6:    id_byte = 8'h05;
      default: id_byte = 8'hB1;
    endcase
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    max2 = (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/uart_addr_dec.sv
module uart_addr_dec
  import uart_regfile_pkg::*;
#(
  parameter int unsigned WORD_W = 10
) (
  input  logic [WORD_W-1:0] word,
  output reg_sel_e          sel,
  output logic [2:0]        id_idx
);

  logic in_id_region;

  // Top eight words of the window form the ID region
  assign in_id_region = &word[WORD_W-1:3];
  assign id_idx       = word[2:0];

  always_comb begin
    sel = SEL_NONE;
    if (in_id_region) begin
      sel = SEL_ID;
    end else begin
      case (int'(word))
        WIDX_DATA:  sel = SEL_DATA;
        WIDX_FLAGS: sel = SEL_FLAGS;
        WIDX_LPDIV: sel = SEL_LPDIV;
        WIDX_IDIV:  sel = SEL_IDIV;
        WIDX_FDIV:  sel = SEL_FDIV;
        WIDX_LCTL:  sel = SEL_LCTL;
        WIDX_CTRL:  sel = SEL_CTRL;
        WIDX_FLVL:  sel = SEL_FLVL;
        WIDX_MASK:  sel = SEL_MASK;
        WIDX_RAW:   sel = SEL_RAW;
        WIDX_MSTAT: sel = SEL_MSTAT;
        WIDX_CLR:   sel = SEL_CLR;
        WIDX_DMA:   sel = SEL_DMA;
        default:    sel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/uart_cfg_regs.sv
module uart_cfg_regs
  import uart_regfile_pkg::*;
#(
  parameter int unsigned LPDIV_W  = 8,
  parameter int unsigned IDIV_W   = 16,
  parameter int unsigned FDIV_W   = 6,
  parameter int unsigned LCTL_W   = 8,
  parameter int unsigned CTRL_W   = 16,
  parameter int unsigned FLVL_W   = 6,
  parameter int unsigned DMA_W    = 3,
  parameter int unsigned CFG_W    = 16,
  parameter logic [CTRL_W-1:0] CTRL_RST = CTRL_W'(16'h0300),
  parameter logic [FLVL_W-1:0] FLVL_RST = FLVL_W'(6'h12)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [CFG_W-1:0]  wdata,
  output logic [LPDIV_W-1:0] lpdiv_q,
  output logic [IDIV_W-1:0]  idiv_q,
  output logic [FDIV_W-1:0]  fdiv_q,
  output logic [LCTL_W-1:0]  lctl_q,
  output logic [CTRL_W-1:0]  ctrl_q,
  output logic [FLVL_W-1:0]  flvl_q,
  output logic [DMA_W-1:0]   dma_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      lpdiv_q <= '0;
      idiv_q  <= '0;
      fdiv_q  <= '0;
      lctl_q  <= '0;
      ctrl_q  <= CTRL_RST;
      flvl_q  <= FLVL_RST;
      dma_q   <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_LPDIV: lpdiv_q <= wdata[LPDIV_W-1:0];
        SEL_IDIV:  idiv_q  <= wdata[IDIV_W-1:0];
        SEL_FDIV:  fdiv_q  <= wdata[FDIV_W-1:0];
        SEL_LCTL:  lctl_q  <= wdata[LCTL_W-1:0];
        SEL_CTRL:  ctrl_q  <= wdata[CTRL_W-1:0];
        SEL_FLVL:  flvl_q  <= wdata[FLVL_W-1:0];
        // DMA enables are held only; no request logic exists
        SEL_DMA:   dma_q   <= wdata[DMA_W-1:0];
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_regfile_pkg::*;
#(
  parameter int unsigned IRQ_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_set,
  input  logic             rx_set,
  input  logic             clr_en,
  input  logic [IRQ_W-1:0] clr_bits,
  input  logic             mask_wr,
  input  logic [IRQ_W-1:0] mask_val,
  output logic [IRQ_W-1:0] raw_q,
  output logic [IRQ_W-1:0] mask_q,
  output logic             irq_q
);

  logic [IRQ_W-1:0] raw_next;
  logic [IRQ_W-1:0] mask_next;

  // Clear first, then new events, so an event in the clear cycle survives
  always_comb begin
    raw_next = raw_q;
    if (clr_en) raw_next = raw_next & ~clr_bits;
    if (tx_set) raw_next[TX_IRQ_BIT] = 1'b1;
    if (rx_set) raw_next[RX_IRQ_BIT] = 1'b1;
  end

  assign mask_next = mask_wr ? mask_val : mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q  <= '0;
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      raw_q  <= raw_next;
      mask_q <= mask_next;
      irq_q  <= |(raw_next & mask_next);
    end
  end

endmodule

// File: rtl/uart_rd_mux.sv
module uart_rd_mux
  import uart_regfile_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned LPDIV_W = 8,
  parameter int unsigned IDIV_W  = 16,
  parameter int unsigned FDIV_W  = 6,
  parameter int unsigned LCTL_W  = 8,
  parameter int unsigned CTRL_W  = 16,
  parameter int unsigned FLVL_W  = 6,
  parameter int unsigned DMA_W   = 3,
  parameter int unsigned IRQ_W   = 11,
  parameter logic [7:0]  FLAGS_VAL = 8'h90
) (
  input  reg_sel_e           sel,
  input  logic [2:0]         id_idx,
  input  logic [LPDIV_W-1:0] lpdiv,
  input  logic [IDIV_W-1:0]  idiv,
  input  logic [FDIV_W-1:0]  fdiv,
  input  logic [LCTL_W-1:0]  lctl,
  input  logic [CTRL_W-1:0]  ctrl,
  input  logic [FLVL_W-1:0]  flvl,
  input  logic [DMA_W-1:0]   dma,
  input  logic [IRQ_W-1:0]   raw,
  input  logic [IRQ_W-1:0]   mask,
  output logic [DATA_W-1:0]  rdata
);

  always_comb begin
    case (sel)
      SEL_FLAGS: rdata = DATA_W'(FLAGS_VAL);
      SEL_LPDIV: rdata = DATA_W'(lpdiv);
      SEL_IDIV:  rdata = DATA_W'(idiv);
      SEL_FDIV:  rdata = DATA_W'(fdiv);
      SEL_LCTL:  rdata = DATA_W'(lctl);
      SEL_CTRL:  rdata = DATA_W'(ctrl);
      SEL_FLVL:  rdata = DATA_W'(flvl);
      SEL_MASK:  rdata = DATA_W'(mask);
      SEL_RAW:   rdata = DATA_W'(raw);
      SEL_MSTAT: rdata = DATA_W'(raw & mask);
      SEL_DMA:   rdata = DATA_W'(dma);
      SEL_ID:    rdata = DATA_W'(id_byte(id_idx));
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/uart_regfile.sv
module uart_regfile
  import uart_regfile_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned LPDIV_W = 8,
  parameter int unsigned IDIV_W  = 16,
  parameter int unsigned FDIV_W  = 6,
  parameter int unsigned LCTL_W  = 8,
  parameter int unsigned CTRL_W  = 16,
  parameter int unsigned FLVL_W  = 6,
  parameter int unsigned DMA_W   = 3,
  parameter int unsigned IRQ_W   = 11,
  parameter logic [7:0]  FLAGS_VAL = 8'h90
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              rx_irq_set,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid,
  output logic [7:0]        tx_byte,
  output logic              tx_valid,
  output logic              irq
);

  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned CFG_W  =
    max2(max2(max2(LPDIV_W, IDIV_W), max2(FDIV_W, LCTL_W)),
         max2(max2(CTRL_W, FLVL_W), DMA_W));

  reg_sel_e          sel;
  logic [2:0]        id_idx;
  logic              wr_en, rd_en;
  logic              tx_wr, clr_en, mask_wr;
  logic [DATA_W-1:0] rd_mux;

  logic [LPDIV_W-1:0] lpdiv_q;
  logic [IDIV_W-1:0]  idiv_q;
  logic [FDIV_W-1:0]  fdiv_q;
  logic [LCTL_W-1:0]  lctl_q;
  logic [CTRL_W-1:0]  ctrl_q;
  logic [FLVL_W-1:0]  flvl_q;
  logic [DMA_W-1:0]   dma_q;
  logic [IRQ_W-1:0]   irq_raw;
  logic [IRQ_W-1:0]   irq_mask;

  // Byte lanes and upper data bits beyond the fields carry no meaning
  logic unused_bus_bits;
  assign unused_bus_bits = ^{bus_wdata, bus_addr[1:0]};

  assign wr_en   = bus_sel & bus_write;
  assign rd_en   = bus_sel & ~bus_write;
  assign tx_wr   = wr_en && (sel == SEL_DATA);
  assign clr_en  = wr_en && (sel == SEL_CLR);
  assign mask_wr = wr_en && (sel == SEL_MASK);

  uart_addr_dec #(.WORD_W(WORD_W)) u_dec (
    .word   (bus_addr[ADDR_W-1:2]),
    .sel    (sel),
    .id_idx (id_idx)
  );

  uart_cfg_regs #(
    .LPDIV_W(LPDIV_W), .IDIV_W(IDIV_W), .FDIV_W(FDIV_W), .LCTL_W(LCTL_W),
    .CTRL_W(CTRL_W), .FLVL_W(FLVL_W), .DMA_W(DMA_W), .CFG_W(CFG_W)
  ) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .sel     (sel),
    .wdata   (bus_wdata[CFG_W-1:0]),
    .lpdiv_q (lpdiv_q),
    .idiv_q  (idiv_q),
    .fdiv_q  (fdiv_q),
    .lctl_q  (lctl_q),
    .ctrl_q  (ctrl_q),
    .flvl_q  (flvl_q),
    .dma_q   (dma_q)
  );

  uart_irq_ctrl #(.IRQ_W(IRQ_W)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .tx_set   (tx_wr),
    .rx_set   (rx_irq_set),
    .clr_en   (clr_en),
    .clr_bits (bus_wdata[IRQ_W-1:0]),
    .mask_wr  (mask_wr),
    .mask_val (bus_wdata[IRQ_W-1:0]),
    .raw_q    (irq_raw),
    .mask_q   (irq_mask),
    .irq_q    (irq)
  );

  uart_rd_mux #(
    .DATA_W(DATA_W), .LPDIV_W(LPDIV_W), .IDIV_W(IDIV_W), .FDIV_W(FDIV_W),
    .LCTL_W(LCTL_W), .CTRL_W(CTRL_W), .FLVL_W(FLVL_W), .DMA_W(DMA_W),
    .IRQ_W(IRQ_W), .FLAGS_VAL(FLAGS_VAL)
  ) u_rd (
    .sel    (sel),
    .id_idx (id_idx),
    .lpdiv  (lpdiv_q),
    .idiv   (idiv_q),
    .fdiv   (fdiv_q),
    .lctl   (lctl_q),
    .ctrl   (ctrl_q),
    .flvl   (flvl_q),
    .dma    (dma_q),
    .raw    (irq_raw),
    .mask   (irq_mask),
    .rdata  (rd_mux)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      tx_byte    <= '0;
      tx_valid   <= 1'b0;
    end else begin
      bus_rvalid <= rd_en;
      if (rd_en) bus_rdata <= rd_mux;
      tx_valid <= tx_wr;
      if (tx_wr) tx_byte <= bus_wdata[7:0];
    end
  end

endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IRQ_W  = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              rx_irq_set,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_rvalid,
  input logic [7:0]        tx_byte,
  input logic              tx_valid,
  input logic              irq,
  input logic [IRQ_W-1:0]  raw,
  input logic [IRQ_W-1:0]  mask
);

  localparam int unsigned WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic data_wr, clr_wr, rd_req, id_rd;
  logic unused_chk_bits;

  assign word    = bus_addr[ADDR_W-1:2];
  assign data_wr = bus_sel && bus_write && (word == WORD_W'(0));
  assign clr_wr  = bus_sel && bus_write && (word == WORD_W'(17));
  assign rd_req  = bus_sel && !bus_write;
  assign id_rd   = rd_req && (&word[WORD_W-1:3]);
  assign unused_chk_bits = ^{bus_addr[1:0], bus_wdata, bus_rdata[7:0]};

  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (|(raw & mask)));

  // R4
  tx_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    data_wr |=> (tx_valid && tx_byte == $past(bus_wdata[7:0]) && raw[5]));

  // R10
  no_stray_tx_chk: assert property (@(posedge clk) disable iff (rst)
    !data_wr |=> !tx_valid);

  // R5
  tx_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (raw[5] && !(clr_wr && bus_wdata[5])) |=> raw[5]);

  // R6
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && !rx_irq_set) |=> ((raw & $past(bus_wdata[IRQ_W-1:0])) == '0));

  // R7
  rx_set_chk: assert property (@(posedge clk) disable iff (rst)
    rx_irq_set |=> raw[4]);

  // R12
  rvalid_rise_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> bus_rvalid);

  // R12
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> !bus_rvalid);

  // R3
  id_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    id_rd |=> (bus_rdata[DATA_W-1:8] == '0));

endmodule

bind uart_regfile uart_regfile_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_W(IRQ_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_sel    (bus_sel),
  .bus_write  (bus_write),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .rx_irq_set (rx_irq_set),
  .bus_rdata  (bus_rdata),
  .bus_rvalid (bus_rvalid),
  .tx_byte    (tx_byte),
  .tx_valid   (tx_valid),
  .irq        (irq),
  .raw        (irq_raw),
  .mask       (irq_mask)
);

// File: tb/tb_uart_regfile.sv
module tb_uart_regfile;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_write = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        rx_irq_set = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [7:0]  tx_byte;
  logic        tx_valid;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;

  rd_item_t   rd_q[$];
  logic [7:0] tx_q[$];

  always #2 clk = ~clk;

  uart_regfile dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rx_irq_set(rx_irq_set),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .tx_byte(tx_byte),
    .tx_valid(tx_valid), .irq(irq)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // Driver tasks: called at a falling edge, return at the next one
  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_write = 1'b0;
  endtask

  task automatic tx_wr(input logic [31:0] d);
    tx_q.push_back(d[7:0]);
    bus_wr(12'h000, d);
  endtask

  task automatic bus_rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    rd_item_t it;
    it.exp = exp;
    it.tag = tag;
    rd_q.push_back(it);
    bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rx_pulse();
    rx_irq_set = 1'b1;
    @(negedge clk);
    rx_irq_set = 1'b0;
  endtask

  // Monitor: pops expected items as results appear
  always @(negedge clk) begin : monitor
    rd_item_t it;
    if (!rst) begin
      if (bus_rvalid) begin
        if (rd_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R12 unexpected read data: got %h expected none", bus_rdata);
        end else begin
          it = rd_q.pop_front();
          check(bus_rdata, it.exp, it.tag);
        end
      end
      if (tx_valid) begin
        if (tx_q.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R10 unexpected tx strobe: got %h expected none", tx_byte);
        end else begin
          check({24'h0, tx_byte}, {24'h0, tx_q.pop_front()}, "R4 tx byte");
        end
      end
    end
  end

  initial begin : watchdog
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check({31'h0, irq}, 32'h0, "R1 irq after reset");
    check({31'h0, tx_valid}, 32'h0, "R1 tx_valid after reset");
    check({31'h0, bus_rvalid}, 32'h0, "R1 rvalid after reset");
    bus_rd(12'h030, 32'h300, "R1 control reset");
    bus_rd(12'h034, 32'h12,  "R1 fifo level reset");
    bus_rd(12'h018, 32'h90,  "R1 flags reset");
    bus_rd(12'h038, 32'h0,   "R1 mask reset");
    bus_rd(12'h03C, 32'h0,   "R1 raw reset");
    bus_rd(12'h024, 32'h0,   "R1 int divisor reset");
    bus_rd(12'h048, 32'h0,   "R1 dma reset");

    // R2 field widths
    bus_wr(12'h020, 32'hFFFF_FFFF);
    check({31'h0, bus_rvalid}, 32'h0, "R12 no rvalid on write");
    bus_wr(12'h024, 32'hFFFF_FFFF);
    bus_wr(12'h028, 32'hFFFF_FFFF);
    bus_wr(12'h02C, 32'hFFFF_FFFF);
    bus_wr(12'h030, 32'hFFFF_FFFF);
    bus_wr(12'h034, 32'hFFFF_FFFF);
    bus_rd(12'h020, 32'hFF,   "R2 low-power divisor width");
    bus_rd(12'h024, 32'hFFFF, "R2 int divisor width");
    bus_rd(12'h028, 32'h3F,   "R2 frac divisor width");
    bus_rd(12'h02C, 32'hFF,   "R2 line control width");
    bus_rd(12'h030, 32'hFFFF, "R2 control width");
    bus_rd(12'h034, 32'h3F,   "R2 fifo level width");
    bus_wr(12'h024, 32'h1234_5678);
    bus_wr(12'h028, 32'h0000_0015);
    bus_rd(12'h024, 32'h5678, "R2 int divisor value");
    bus_rd(12'h028, 32'h15,   "R2 frac divisor value");

    // R3 ID sequence
    bus_rd(12'hFE0, 32'h11, "R3 id 0");
    bus_rd(12'hFE4, 32'h10, "R3 id 1");
    bus_rd(12'hFE8, 32'h14, "R3 id 2");
    bus_rd(12'hFEC, 32'h00, "R3 id 3");
    bus_rd(12'hFF0, 32'h0D, "R3 id 4");
    bus_rd(12'hFF4, 32'hF0, "R3 id 5");
    bus_rd(12'hFF8, 32'h05, "R3 id 6");
    bus_rd(12'hFFC, 32'hB1, "R3 id 7");

    // R4 transmit write
    tx_wr(32'h0000_A5C3);
    check({31'h0, tx_valid}, 32'h1, "R4 tx_valid after data write");
    @(negedge clk);
    check({31'h0, tx_valid}, 32'h0, "R4 tx_valid one cycle only");
    bus_rd(12'h03C, 32'h20, "R4 raw tx bit set");
    check({31'h0, irq}, 32'h0, "R8 irq low with mask 0");
    bus_wr(12'h038, 32'h20);
    check({31'h0, irq}, 32'h1, "R8 irq rises on mask write");
    bus_rd(12'h040, 32'h20, "R9 masked status tx");
    bus_rd(12'h03C, 32'h20, "R5 tx bit still set");

    // R6 clear
    bus_wr(12'h044, 32'h10);
    bus_rd(12'h03C, 32'h20, "R6 clear of other bit leaves tx");
    check({31'h0, irq}, 32'h1, "R5 irq held");
    bus_wr(12'h044, 32'h20);
    check({31'h0, irq}, 32'h0, "R8 irq falls on clear");
    bus_rd(12'h03C, 32'h0, "R6 tx bit cleared");

    // R7 receive request
    rx_pulse();
    bus_rd(12'h03C, 32'h10, "R7 raw rx bit set");
    check({31'h0, irq}, 32'h0, "R8 rx masked off");
    bus_rd(12'h040, 32'h0, "R9 masked status zero");
    bus_wr(12'h038, 32'h30);
    check({31'h0, irq}, 32'h1, "R8 irq on rx enable");
    bus_rd(12'h040, 32'h10, "R9 masked status rx");

    // R6 clear and receive in the same cycle
    rx_irq_set = 1'b1;
    bus_wr(12'h044, 32'h10);
    rx_irq_set = 1'b0;
    bus_rd(12'h03C, 32'h10, "R6 rx set wins over clear");
    tx_wr(32'h0000_0042);
    bus_rd(12'h03C, 32'h30, "R9 raw both bits");
    bus_wr(12'h044, 32'h7FF);
    bus_rd(12'h03C, 32'h0, "R6 clear all");
    check({31'h0, irq}, 32'h0, "R8 irq low after clear all");

    // R10 ignored writes and zero reads
    bus_wr(12'h018, 32'hFFFF_FFFF);
    bus_rd(12'h018, 32'h90, "R10 flags read-only");
    bus_wr(12'h03C, 32'h30);
    bus_rd(12'h03C, 32'h0, "R10 raw read-only");
    check({31'h0, irq}, 32'h0, "R10 irq after raw write");
    bus_wr(12'h040, 32'h30);
    bus_rd(12'h03C, 32'h0, "R10 masked write ignored");
    bus_wr(12'h004, 32'h0000_0001);
    bus_rd(12'h030, 32'hFFFF, "R10 word1 write ignored");
    bus_rd(12'h004, 32'h0, "R10 word1 reads zero");
    bus_rd(12'h000, 32'h0, "R10 data reads zero");
    bus_rd(12'h044, 32'h0, "R10 clear reads zero");
    bus_wr(12'h080, 32'hDEAD_BEEF);
    bus_rd(12'h080, 32'h0, "R10 unmapped reads zero");
    bus_rd(12'h04C, 32'h0, "R10 unmapped 19 zero");
    bus_rd(12'hFC0, 32'h0, "R10 unmapped below id zero");
    bus_wr(12'hFE0, 32'hFFFF_FFFF);
    bus_rd(12'hFE0, 32'h11, "R10 id write ignored");

    // R11 DMA control
    bus_wr(12'h048, 32'hFFFF_FFFF);
    bus_rd(12'h048, 32'h7, "R11 dma store all bits");
    check({31'h0, irq}, 32'h0, "R11 irq unaffected by dma");
    bus_wr(12'h048, 32'hFFFF_FFF8);
    bus_rd(12'h048, 32'h0, "R11 dma cleared");

    // R8 mask removal with raw set
    rx_pulse();
    check({31'h0, irq}, 32'h1, "R8 irq on rx with mask");
    bus_wr(12'h038, 32'h0);
    check({31'h0, irq}, 32'h0, "R8 irq falls on mask clear");

    repeat (3) @(negedge clk);
    check(rd_q.size(), 32'h0, "R12 all reads answered");
    check(tx_q.size(), 32'h0, "R4 all bytes sent");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule